// File: doc/BRIEF.md
# Line Loopback and All-Ones Selector

This block steers the digital data paths of a single-channel T1/E1 line interface. It sits between the framer side (dual-rail transmit data with its clock), the receive side (recovered dual-rail data with its clock) and the jitter-attenuator core (its smoothed output). It chooses where each stream goes: to the line tip/ring rails, to the receive outputs, or into the jitter attenuator. Every clock is modelled as a single-cycle strobe inside one system clock domain, so a rail pulse is valid only in a cycle where its strobe is high.

Four path configurations are chosen from a two-bit loop code: normal, digital local loop (transmit stream to receive outputs), remote loop (recovered stream back to the line) and local loop (jitter-attenuator output to receive outputs). A two-bit attenuator-placement code puts the attenuator in the transmit path, in the receive path, or nowhere. A fixed precedence sets how the two codes combine with the all-ones (alarm indication) request. A chip-select input chooses between passing the configuration straight through and holding a captured copy. The request for all ones is never held. An active-low in-circuit-test input turns off every output enable.

The design has three state machines. The configuration holder has the states CFG_TRACK and CFG_HOLD. It goes from CFG_TRACK to CFG_HOLD on a clock where chip select is sampled high, and from CFG_HOLD to CFG_TRACK on a clock where chip select is sampled low. The mark generator has the states MARK_POS and MARK_NEG and moves between them on every reference strobe. The path decoder resolves the request into one of four path states: LP_NORMAL, LP_DIGITAL, LP_REMOTE and LP_LOCAL.

Top module: `line_loop_ais_sel`

## Requirements
- R1: With loop code 00 (normal) and placement 00, the line rails carry the transmit stream and the receive outputs carry the recovered stream, each one clock after the input cycle.
- R2: With loop code 01 (digital local loop), the receive outputs carry the transmit stream. The line still carries the transmit stream, or all ones when requested.
- R3: With loop code 10 (remote loop), the line carries the recovered stream, or the attenuator output when placement is 01 or 10. The transmit stream and the all-ones request are ignored, and the receive outputs still carry the recovered stream (the attenuator output when placement is 10).
- R4: With loop code 11 and placement 01, the receive outputs and the line both carry the attenuator output, and the attenuator input is fed from the transmit stream. An all-ones request changes only the line.
- R5: With loop code 11 and any placement other than 01, the block behaves exactly as the digital local loop.
- R6: While all ones is requested (outside remote loop), the line pulses once per reference strobe and ignores the transmit data. The first mark after reset is positive (tip), and later marks alternate tip and ring, one per strobe. Without a strobe there is no pulse.
- R7: The rail outputs are encoded as {strobe, tip/pos, ring/neg}. A positive one is a tip pulse and a negative one is a ring pulse. A rail pulse appears only with its strobe. An input cycle with both rails high, or with neither, produces a strobe with no pulse.
- R8: Placement code 01 feeds the attenuator input from the transmit stream and drives the line from the attenuator output. Code 10 feeds the attenuator input from the recovered stream and drives the receive outputs from the attenuator output. Codes 00 and 11 leave the attenuator input idle (all zero).
- R9: While chip select is low, the loop, placement and equalizer codes take effect directly. From the first clock where chip select is sampled high, the codes present in that cycle are held until one clock after chip select is sampled low. The all-ones request is always live.
- R10: When the in-circuit-test input is low, both output enables are low. When it is high, both are high.
- R11: During reset and in the first cycle after it, all rail outputs and the attenuator input are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_stb | input | 1 | Transmit clock strobe |
| tx_pos | input | 1 | Transmit positive rail |
| tx_neg | input | 1 | Transmit negative rail |
| rx_stb | input | 1 | Recovered clock strobe |
| rx_pos | input | 1 | Recovered positive rail |
| rx_neg | input | 1 | Recovered negative rail |
| ja_stb | input | 1 | Attenuator output clock strobe |
| ja_pos | input | 1 | Attenuator output positive rail |
| ja_neg | input | 1 | Attenuator output negative rail |
| ref_stb | input | 1 | External reference clock strobe |
| cfg_sel | input | 1 | Chip select: 0 pass-through, 1 hold |
| cfg_loop | input | 2 | Loop code |
| cfg_ja | input | 2 | Attenuator placement code |
| cfg_eq | input | EQ_W | Transmit equalizer code |
| ais_req | input | 1 | All-ones request (never held) |
| ict_n | input | 1 | In-circuit test, active low |
| line_stb | output | 1 | Line clock strobe |
| line_tip | output | 1 | Line tip pulse (positive one) |
| line_ring | output | 1 | Line ring pulse (negative one) |
| line_oe | output | 1 | Line output enable |
| rcv_stb | output | 1 | Receive output clock strobe |
| rcv_pos | output | 1 | Receive positive rail |
| rcv_neg | output | 1 | Receive negative rail |
| rcv_oe | output | 1 | Receive output enable |
| jain_stb | output | 1 | Attenuator input clock strobe |
| jain_pos | output | 1 | Attenuator input positive rail |
| jain_neg | output | 1 | Attenuator input negative rail |
| eq_sel | output | EQ_W | Effective equalizer code |

## Verification
The assertions check four things on every cycle. The line rails never carry both marks at once, and a mark never appears without its strobe. The mark generator flips polarity on every reference strobe. The held configuration stays stable while chip select remains high. In remote, local and digital loops, the strobe of each output follows its chosen source one clock later, and the enables follow the test input. Only the bench scenarios can show which stream each configuration picks, that the all-ones sequence starts positive after reset, how all ones and remote loop take precedence, that local loop falls back to digital, and which value the hold captures across chip-select edges.

// File: rtl/llas_pkg.sv
package llas_pkg;

    typedef struct packed {
        logic stb;
        logic pos;
        logic neg;
    } rail_t;

    typedef enum logic [1:0] {
        LP_NORMAL  = 2'b00,
        LP_DIGITAL = 2'b01,
        LP_REMOTE  = 2'b10,
        LP_LOCAL   = 2'b11
    } loop_e;

    typedef enum logic [1:0] {
        JA_OFF  = 2'b00,
        JA_TX   = 2'b01,
        JA_RX   = 2'b10,
        JA_TEST = 2'b11
    } ja_e;

    localparam rail_t RAIL_IDLE = '0;

    // keep a mark only under its strobe; both rails high counts as a zero
    function automatic rail_t rail_clean(input rail_t r);
        rail_t o;
        o.stb = r.stb;
        o.pos = r.stb & r.pos & ~r.neg;
        o.neg = r.stb & r.neg & ~r.pos;
        return o;
    endfunction

endpackage

// File: rtl/llas_cfg_hold.sv
module llas_cfg_hold #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic [W-1:0] cfg_in,
    output logic [W-1:0] cfg_eff
);

    typedef enum logic {
        CFG_TRACK = 1'b0,
        CFG_HOLD  = 1'b1
    } cfg_st_e;

    cfg_st_e      state, state_nxt;
    logic [W-1:0] shadow;

    always_comb begin
        state_nxt = state;
        unique case (state)
            CFG_TRACK: if (sel)  state_nxt = CFG_HOLD;
            CFG_HOLD:  if (!sel) state_nxt = CFG_TRACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CFG_TRACK;
        else        state <= state_nxt;
    end

    // shadow follows the pins while tracking, freezes once holding
    always_ff @(posedge clk) begin
        if (!rst_n)                 shadow <= '0;
        else if (state == CFG_TRACK) shadow <= cfg_in;
    end

    always_comb begin
        cfg_eff = cfg_in;
        unique case (state)
            CFG_TRACK: cfg_eff = cfg_in;
            CFG_HOLD:  cfg_eff = shadow;
        endcase
    end

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CFG_HOLD && $past(state) == CFG_HOLD) |-> $stable(cfg_eff));

endmodule

// File: rtl/llas_ais_gen.sv
module llas_ais_gen
    import llas_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ref_stb,
    output rail_t ais
);

    typedef enum logic {
        MARK_POS = 1'b0,
        MARK_NEG = 1'b1
    } mark_e;

    mark_e mark, mark_nxt;

    always_comb begin
        mark_nxt = mark;
        unique case (mark)
            MARK_POS: if (ref_stb) mark_nxt = MARK_NEG;
            MARK_NEG: if (ref_stb) mark_nxt = MARK_POS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mark <= MARK_POS;
        else        mark <= mark_nxt;
    end

    always_comb begin
        ais = RAIL_IDLE;
        ais.stb = ref_stb;
        unique case (mark)
            MARK_POS: ais.pos = ref_stb;
            MARK_NEG: ais.neg = ref_stb;
        endcase
    end

    assert_mark_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb |=> (mark != $past(mark)));

    assert_mark_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ais.pos, ais.neg}));

endmodule

// File: rtl/llas_path_sel.sv
module llas_path_sel
    import llas_pkg::*;
(
    input  logic [1:0] loop_req,
    input  logic [1:0] ja_req,
    input  logic       ais_req,
    input  rail_t      tx,
    input  rail_t      rx,
    input  rail_t      ja_out,
    input  rail_t      ais,
    output rail_t      line_nxt,
    output rail_t      rcv_nxt,
    output rail_t      ja_in_nxt,
    output loop_e      lp_act,
    output ja_e        ja_act
);

    rail_t line_base;

    // test placement steers like bypass; local loop needs the transmit placement
    always_comb begin
        ja_act = (ja_e'(ja_req) == JA_TEST) ? JA_OFF : ja_e'(ja_req);
        lp_act = loop_e'(loop_req);
        if (lp_act == LP_LOCAL && ja_act != JA_TX) lp_act = LP_DIGITAL;
    end

    always_comb begin
        line_base = RAIL_IDLE;
        rcv_nxt   = RAIL_IDLE;
        ja_in_nxt = RAIL_IDLE;
        unique case (lp_act)
            LP_NORMAL: begin
                ja_in_nxt = (ja_act == JA_TX) ? tx : (ja_act == JA_RX) ? rx : RAIL_IDLE;
                line_base = (ja_act == JA_TX) ? ja_out : tx;
                rcv_nxt   = (ja_act == JA_RX) ? ja_out : rx;
            end
            LP_DIGITAL: begin
                ja_in_nxt = (ja_act == JA_TX) ? tx : (ja_act == JA_RX) ? rx : RAIL_IDLE;
                line_base = (ja_act == JA_TX) ? ja_out : tx;
                rcv_nxt   = tx;
            end
            LP_REMOTE: begin
                ja_in_nxt = (ja_act != JA_OFF) ? rx : RAIL_IDLE;
                line_base = (ja_act != JA_OFF) ? ja_out : rx;
                rcv_nxt   = (ja_act == JA_RX) ? ja_out : rx;
            end
            LP_LOCAL: begin
                ja_in_nxt = tx;
                line_base = ja_out;
                rcv_nxt   = ja_out;
            end
        endcase
        // remote loop outranks the all-ones request
        line_nxt = (ais_req && lp_act != LP_REMOTE) ? ais : line_base;
    end

endmodule

// File: rtl/line_loop_ais_sel.sv
module line_loop_ais_sel
    import llas_pkg::*;
#(
    parameter int EQ_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_stb,
    input  logic            tx_pos,
    input  logic            tx_neg,
    input  logic            rx_stb,
    input  logic            rx_pos,
    input  logic            rx_neg,
    input  logic            ja_stb,
    input  logic            ja_pos,
    input  logic            ja_neg,
    input  logic            ref_stb,
    input  logic            cfg_sel,
    input  logic [1:0]      cfg_loop,
    input  logic [1:0]      cfg_ja,
    input  logic [EQ_W-1:0] cfg_eq,
    input  logic            ais_req,
    input  logic            ict_n,
    output logic            line_stb,
    output logic            line_tip,
    output logic            line_ring,
    output logic            line_oe,
    output logic            rcv_stb,
    output logic            rcv_pos,
    output logic            rcv_neg,
    output logic            rcv_oe,
    output logic            jain_stb,
    output logic            jain_pos,
    output logic            jain_neg,
    output logic [EQ_W-1:0] eq_sel
);

    localparam int CFG_W = EQ_W + 4;

    logic [CFG_W-1:0] cfg_eff;
    rail_t tx_r, rx_r, ja_r, ais_r;
    rail_t line_nxt, rcv_nxt, jain_nxt;
    rail_t line_q, rcv_q, jain_q;
    loop_e lp_act;
    ja_e   ja_act;

    assign tx_r = rail_clean('{stb: tx_stb, pos: tx_pos, neg: tx_neg});
    assign rx_r = rail_clean('{stb: rx_stb, pos: rx_pos, neg: rx_neg});
    assign ja_r = rail_clean('{stb: ja_stb, pos: ja_pos, neg: ja_neg});

    llas_cfg_hold #(.W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (cfg_sel),
        .cfg_in  ({cfg_eq, cfg_ja, cfg_loop}),
        .cfg_eff (cfg_eff)
    );

    llas_ais_gen u_ais (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_stb (ref_stb),
        .ais     (ais_r)
    );

    llas_path_sel u_path (
        .loop_req  (cfg_eff[1:0]),
        .ja_req    (cfg_eff[3:2]),
        .ais_req   (ais_req),
        .tx        (tx_r),
        .rx        (rx_r),
        .ja_out    (ja_r),
        .ais       (ais_r),
        .line_nxt  (line_nxt),
        .rcv_nxt   (rcv_nxt),
        .ja_in_nxt (jain_nxt),
        .lp_act    (lp_act),
        .ja_act    (ja_act)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= RAIL_IDLE;
            rcv_q  <= RAIL_IDLE;
            jain_q <= RAIL_IDLE;
        end else begin
            line_q <= line_nxt;
            rcv_q  <= rcv_nxt;
            jain_q <= jain_nxt;
        end
    end

    assign {line_stb, line_tip, line_ring} = line_q;
    assign {rcv_stb, rcv_pos, rcv_neg}     = rcv_q;
    assign {jain_stb, jain_pos, jain_neg}  = jain_q;
    assign line_oe = ict_n;
    assign rcv_oe  = ict_n;
    assign eq_sel  = cfg_eff[CFG_W-1:4];

    assert_line_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({line_tip, line_ring}) && ((line_tip || line_ring) -> line_stb));

    assert_remote_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_act == LP_REMOTE && ja_act == JA_OFF) |=> (line_stb == $past(rx_stb)));

    assert_local_rcv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_act == LP_LOCAL) |=> (rcv_stb == $past(ja_stb)));

    assert_digital_rcv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_act == LP_DIGITAL) |=> (rcv_stb == $past(tx_stb)));

    assert_ict_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ict_n |-> (!line_oe && !rcv_oe));

endmodule

// File: tb/line_loop_ais_sel_test.sv
module line_loop_ais_sel_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_stb = 0, tx_pos = 0, tx_neg = 0;
    logic rx_stb = 0, rx_pos = 0, rx_neg = 0;
    logic ja_stb = 0, ja_pos = 0, ja_neg = 0;
    logic ref_stb = 0, cfg_sel = 0, ais_req = 0, ict_n = 1;
    logic [1:0] cfg_loop = 0, cfg_ja = 0;
    logic [2:0] cfg_eq = 0;
    logic line_stb, line_tip, line_ring, line_oe;
    logic rcv_stb, rcv_pos, rcv_neg, rcv_oe;
    logic jain_stb, jain_pos, jain_neg;
    logic [2:0] eq_sel;

    int checks = 0;
    int fails = 0;
    logic nxt_pos = 1'b1;
    logic done = 1'b0;

    always #10 clk = ~clk;

    line_loop_ais_sel #(.EQ_W(3)) uut (
        .clk(clk), .rst_n(rst_n),
        .tx_stb(tx_stb), .tx_pos(tx_pos), .tx_neg(tx_neg),
        .rx_stb(rx_stb), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .ja_stb(ja_stb), .ja_pos(ja_pos), .ja_neg(ja_neg),
        .ref_stb(ref_stb), .cfg_sel(cfg_sel), .cfg_loop(cfg_loop),
        .cfg_ja(cfg_ja), .cfg_eq(cfg_eq), .ais_req(ais_req), .ict_n(ict_n),
        .line_stb(line_stb), .line_tip(line_tip), .line_ring(line_ring), .line_oe(line_oe),
        .rcv_stb(rcv_stb), .rcv_pos(rcv_pos), .rcv_neg(rcv_neg), .rcv_oe(rcv_oe),
        .jain_stb(jain_stb), .jain_pos(jain_pos), .jain_neg(jain_neg), .eq_sel(eq_sel)
    );

    function automatic logic [2:0] line_v(); return {line_stb, line_tip, line_ring}; endfunction
    function automatic logic [2:0] rcv_v();  return {rcv_stb, rcv_pos, rcv_neg};     endfunction
    function automatic logic [2:0] jain_v(); return {jain_stb, jain_pos, jain_neg};  endfunction
    function automatic logic [2:0] ais_v();
        return ref_stb ? (nxt_pos ? 3'b110 : 3'b101) : 3'b000;
    endfunction

    task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [2:0] t, input logic [2:0] r, input logic [2:0] j);
        {tx_stb, tx_pos, tx_neg} = t;
        {rx_stb, rx_pos, rx_neg} = r;
        {ja_stb, ja_pos, ja_neg} = j;
    endtask

    task automatic step();
        logic r;
        r = ref_stb;
        @(negedge clk);
        if (r) nxt_pos = ~nxt_pos;
    endtask

    task automatic t_reset();
        chk("R11 line after reset", line_v(), 3'b000);
        chk("R11 rcv after reset", rcv_v(), 3'b000);
        chk("R11 jain after reset", jain_v(), 3'b000);
    endtask

    task automatic t_normal();
        cfg_loop = 2'b00; cfg_ja = 2'b00; ais_req = 0;
        drive(3'b110, 3'b101, 3'b110); step();
        chk("R1 normal line=tx", line_v(), 3'b110);
        chk("R1 normal rcv=rx", rcv_v(), 3'b101);
        chk("R8 bypass jain idle", jain_v(), 3'b000);
        drive(3'b111, 3'b100, 3'b000); step();
        chk("R7 both rails -> zero", line_v(), 3'b100);
        chk("R7 no-mark strobe", rcv_v(), 3'b100);
        drive(3'b010, 3'b001, 3'b000); step();
        chk("R7 no strobe no pulse line", line_v(), 3'b000);
        chk("R7 no strobe no pulse rcv", rcv_v(), 3'b000);
    endtask

    task automatic t_digital();
        cfg_loop = 2'b01; cfg_ja = 2'b00; ais_req = 0;
        drive(3'b101, 3'b110, 3'b000); step();
        chk("R2 digital rcv=tx", rcv_v(), 3'b101);
        chk("R2 digital line=tx", line_v(), 3'b101);
        ais_req = 1; ref_stb = 1;
        chk("R2 digital ais", 3'b000, 3'b000);
        begin
            logic [2:0] e;
            e = ais_v();
            step();
            chk("R2 digital line=ais", line_v(), e);
            chk("R2 digital rcv still tx", rcv_v(), 3'b101);
        end
        ais_req = 0; ref_stb = 0;
    endtask

    task automatic t_remote();
        cfg_loop = 2'b10; cfg_ja = 2'b00; ais_req = 1; ref_stb = 1;
        drive(3'b110, 3'b101, 3'b000); step();
        chk("R3 remote line=rx, ais ignored", line_v(), 3'b101);
        chk("R3 remote rcv=rx", rcv_v(), 3'b101);
        ref_stb = 0;
        cfg_ja = 2'b10;
        drive(3'b101, 3'b101, 3'b110); step();
        chk("R3 remote rx-path line=ja", line_v(), 3'b110);
        chk("R3 remote rx-path rcv=ja", rcv_v(), 3'b110);
        chk("R8 rx-path jain=rx", jain_v(), 3'b101);
        ais_req = 0;
    endtask

    task automatic t_local();
        logic [2:0] e;
        cfg_loop = 2'b11; cfg_ja = 2'b01; ais_req = 0;
        drive(3'b110, 3'b110, 3'b101); step();
        chk("R4 local rcv=ja", rcv_v(), 3'b101);
        chk("R4 local line=ja", line_v(), 3'b101);
        chk("R4 local jain=tx", jain_v(), 3'b110);
        ais_req = 1; ref_stb = 1;
        e = ais_v();
        step();
        chk("R4 local line=ais", line_v(), e);
        chk("R4 local rcv unaffected", rcv_v(), 3'b101);
        ais_req = 0; ref_stb = 0;
    endtask

    task automatic t_fallback();
        cfg_loop = 2'b11; cfg_ja = 2'b00;
        drive(3'b101, 3'b110, 3'b110); step();
        chk("R5 local mode00 acts digital", rcv_v(), 3'b101);
        cfg_ja = 2'b11;
        drive(3'b110, 3'b101, 3'b101); step();
        chk("R5 local mode11 acts digital", rcv_v(), 3'b110);
        chk("R8 test mode jain idle", jain_v(), 3'b000);
        chk("R8 test mode line=tx", line_v(), 3'b110);
    endtask

    task automatic t_ais();
        logic [2:0] e;
        cfg_loop = 2'b00; cfg_ja = 2'b00; ais_req = 1;
        drive(3'b101, 3'b000, 3'b000);
        for (int i = 0; i < 6; i++) begin
            ref_stb = (i != 2);
            e = ais_v();
            step();
            chk("R6 ais sequence", line_v(), e);
        end
        ref_stb = 0; ais_req = 0;
    endtask

    task automatic t_ja_rx();
        cfg_loop = 2'b00; cfg_ja = 2'b10;
        drive(3'b110, 3'b101, 3'b111); step();
        chk("R8 rx-path rcv=ja (both rails->zero)", rcv_v(), 3'b100);
        chk("R8 rx-path jain=rx", jain_v(), 3'b101);
        chk("R8 rx-path line=tx", line_v(), 3'b110);
        cfg_ja = 2'b01;
        drive(3'b101, 3'b000, 3'b110); step();
        chk("R8 tx-path line=ja", line_v(), 3'b110);
        chk("R8 tx-path jain=tx", jain_v(), 3'b101);
    endtask

    task automatic t_cfg();
        logic [2:0] e;
        cfg_sel = 0; cfg_loop = 2'b01; cfg_ja = 2'b00; cfg_eq = 3'b011;
        #1 chk("R9 eq pass-through", eq_sel, 3'b011);
        cfg_sel = 1;
        drive(3'b110, 3'b101, 3'b000); step();
        chk("R9 capture cycle digital", rcv_v(), 3'b110);
        cfg_loop = 2'b00; cfg_eq = 3'b110;
        drive(3'b101, 3'b110, 3'b000);
        #1 chk("R9 eq held", eq_sel, 3'b011);
        ais_req = 1; ref_stb = 1;
        e = ais_v();
        step();
        chk("R9 loop held digital", rcv_v(), 3'b101);
        chk("R9 ais not held", line_v(), e);
        ais_req = 0; ref_stb = 0;
        cfg_sel = 0; step();
        drive(3'b101, 3'b110, 3'b000); step();
        chk("R9 released normal", rcv_v(), 3'b110);
        chk("R9 eq released", eq_sel, 3'b110);
    endtask

    task automatic t_ict();
        ict_n = 0;
        #1 chk("R10 ict low enables", {1'b0, line_oe, rcv_oe}, 3'b000);
        ict_n = 1;
        #1 chk("R10 ict high enables", {1'b0, line_oe, rcv_oe}, 3'b011);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 line in reset", line_v(), 3'b000);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_digital();
        t_remote();
        t_local();
        t_fallback();
        t_ais();
        t_ja_rx();
        t_cfg();
        t_ict();
        done = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

endmodule